// File: doc/BRIEF.md
# Up-counting compare timer

This block is a 16-bit timer that counts upward from zero on a clock-enable input. Enabling it takes the current value of compare register A as the period. The counter runs from zero up to that value and then wraps back to zero. On each wrap it emits a one-cycle period pulse.

Two match outputs give extra timing points inside each period. One fires when the counter reaches compare A, and the other when it reaches compare B. Each is gated by bit 0 of its own compare-mode register.

Software reaches the block through a byte-addressed register bus that takes 8-bit and 16-bit writes. Reads are combinational. A write that breaks the access rules is dropped as a whole, and an error strobe marks it one cycle later. Reserved mode bits are never stored and always read as zero.

Top module: `upcmp_timer`

## Requirements
- R1: After reset every register, the counter and the outputs `periodPulse`, `matchA`, `matchB`, `busErr` are zero.
- R2: While running, the counter advances by one only on cycles with `tickEn` high. On cycles with `tickEn` low it holds its value.
- R3: Some mode bits are reserved and are never stored. In the mode low byte (address 0) these are bits 5, 3 and 2. In the mode high byte (address 1) these are bits 2:0. All of them read as zero.
- R4: The mode high byte has count enable at bit 7 and load at bit 6. A write that sets both is illegal. It is dropped, and `busErr` is high for one cycle right after it.
- R5: The following writes are also dropped, each followed by a one-cycle `busErr`:
  - a wide write (`busWide`=1) at an odd address;
  - a wide write at address 6;
  - any write to address 8 or 9;
  - any write to an address of 10 or more.
- R6: The address map is:
  - 0 and 1: mode low and mode high;
  - 2 and 3: compare A, low byte then high byte;
  - 4 and 5: compare B, low byte then high byte;
  - 6 and 7: compare-mode A and compare-mode B;
  - 8 and 9: the counter, low byte then high byte, read-only.
  A wide access at even address a carries byte a on bits 7:0 and byte a+1 on bits 15:8. A narrow read returns its byte on bits 7:0 with the upper bits zero.
- R7: A legal write to the mode high byte with bit 7 set latches compare A as the period P and restarts the counter at zero. The counter runs 0..P. The tick taken at P returns it to zero and raises `periodPulse` for exactly one cycle, so a pulse comes every P+1 ticks.
- R8: `matchA` is high for one cycle right after the tick that brings the counter to P, when bit 0 of compare-mode A is set.
- R9: `matchB` is high for one cycle right after the tick that brings the counter to compare B. This happens only when compare B is below P and bit 0 of compare-mode B is set. With compare B equal to 0, the pulse comes with each wrap.
- R10: With a latched period of zero the timer stays idle: the counter reads zero and no pulse is produced.
- R11: A legal write to the mode high byte with bit 7 clear stops the timer. The counter reads zero and no further pulse is produced.
- R12: Writing compare A while running leaves the running period unchanged until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count enable for the counter |
| busWr | input | 1 | Write strobe |
| busWide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data |
| busErr | output | 1 | One-cycle strobe after a dropped write |
| periodPulse | output | 1 | One-cycle pulse on each wrap |
| matchA | output | 1 | Compare A match pulse |
| matchB | output | 1 | Compare B match pulse |

## Verification
The properties check every cycle that:
- pulses last one cycle and the counter is zero at each wrap;
- the counter never passes the latched period;
- a stopped timer holds zero and an idle timer with a zero period is silent;
- the counter holds without a tick;
- illegal writes raise the error strobe.

Only the bench scenarios can show that the pulses land on the exact tick numbers for several periods and compare values. The same holds for the correct effect of the match gating bits, for a period change that waits for the next enable, and for readback of the byte lanes through the bus.

// File: rtl/upcmp_pkg.sv
package upcmp_pkg;
  localparam int CNT_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int BUS_W     = 2 * BYTE_W;
  localparam int NUM_BYTES = 10;

  // byte addresses (wide accesses pair an even address with the next one)
  localparam int A_MODE_LO = 0;
  localparam int A_MODE_HI = 1;
  localparam int A_CMPA_LO = 2;
  localparam int A_CMPA_HI = 3;
  localparam int A_CMPB_LO = 4;
  localparam int A_CMPB_HI = 5;
  localparam int A_CMODE_A = 6;
  localparam int A_CMODE_B = 7;
  localparam int A_CNT_LO  = 8;
  localparam int A_CNT_HI  = 9;

  localparam logic [BYTE_W-1:0] MODE_LO_RSVD = 8'h2C;
  localparam logic [BYTE_W-1:0] MODE_HI_RSVD = 8'h07;
  localparam int RUN_BIT  = 7;
  localparam int LOAD_BIT = 6;
  localparam int GATE_BIT = 0;

  typedef struct packed {
    logic start;  // latch period, restart from zero
    logic clear;  // stop request
    logic run;    // count enable as stored
    logic enA;    // compare A match gate
    logic enB;    // compare B match gate
  } ctrl_t;
endpackage

// File: rtl/upcmp_ctrl.sv
module upcmp_ctrl
  import upcmp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busErr,
  input  logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  cmpAVal,
  output logic [CNT_W-1:0]  cmpBVal,
  output ctrl_t             ctrl
);
  logic [BYTE_W-1:0] modeLo, modeHi, cmodeA, cmodeB;
  logic [NUM_BYTES-1:0] laneWe;
  logic [BYTE_W-1:0] laneVal [NUM_BYTES];
  logic [BYTE_W-1:0] rdLane  [NUM_BYTES];
  logic illegal, wrOk;

  // byte-lane steering shared by write and read
  always_comb begin
    laneWe = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      laneVal[i] = '0;
      if (busAddr == ADDR_W'(i)) begin
        laneWe[i]  = busWr;
        laneVal[i] = busWdata[BYTE_W-1:0];
      end else if (busWide && (i % 2 == 1) && busAddr == ADDR_W'(i - 1)) begin
        laneWe[i]  = busWr;
        laneVal[i] = busWdata[BUS_W-1:BYTE_W];
      end
    end
  end

  always_comb begin
    illegal = 1'b0;
    if (busWide && busAddr[0]) illegal = 1'b1;
    if (busAddr >= ADDR_W'(NUM_BYTES)) illegal = 1'b1;
    if (busWide && busAddr == ADDR_W'(A_CMODE_A)) illegal = 1'b1;
    if (laneWe[A_CNT_LO] || laneWe[A_CNT_HI]) illegal = 1'b1;
    if (laneWe[A_MODE_HI] && laneVal[A_MODE_HI][RUN_BIT] && laneVal[A_MODE_HI][LOAD_BIT])
      illegal = 1'b1;
    wrOk = busWr && !illegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLo  <= '0;
      modeHi  <= '0;
      cmodeA  <= '0;
      cmodeB  <= '0;
      cmpAVal <= '0;
      cmpBVal <= '0;
      busErr  <= 1'b0;
    end else begin
      busErr <= busWr && illegal;
      if (wrOk) begin
        if (laneWe[A_MODE_LO]) modeLo <= laneVal[A_MODE_LO] & ~MODE_LO_RSVD;
        if (laneWe[A_MODE_HI]) modeHi <= laneVal[A_MODE_HI] & ~MODE_HI_RSVD;
        if (laneWe[A_CMPA_LO]) cmpAVal[BYTE_W-1:0]     <= laneVal[A_CMPA_LO];
        if (laneWe[A_CMPA_HI]) cmpAVal[CNT_W-1:BYTE_W] <= laneVal[A_CMPA_HI];
        if (laneWe[A_CMPB_LO]) cmpBVal[BYTE_W-1:0]     <= laneVal[A_CMPB_LO];
        if (laneWe[A_CMPB_HI]) cmpBVal[CNT_W-1:BYTE_W] <= laneVal[A_CMPB_HI];
        if (laneWe[A_CMODE_A]) cmodeA <= laneVal[A_CMODE_A];
        if (laneWe[A_CMODE_B]) cmodeB <= laneVal[A_CMODE_B];
      end
    end
  end

  always_comb begin
    ctrl.start = wrOk && laneWe[A_MODE_HI] && laneVal[A_MODE_HI][RUN_BIT];
    ctrl.clear = wrOk && laneWe[A_MODE_HI] && !laneVal[A_MODE_HI][RUN_BIT];
    ctrl.run   = modeHi[RUN_BIT];
    ctrl.enA   = cmodeA[GATE_BIT];
    ctrl.enB   = cmodeB[GATE_BIT];
  end

  always_comb begin
    rdLane[A_MODE_LO] = modeLo;
    rdLane[A_MODE_HI] = modeHi;
    rdLane[A_CMPA_LO] = cmpAVal[BYTE_W-1:0];
    rdLane[A_CMPA_HI] = cmpAVal[CNT_W-1:BYTE_W];
    rdLane[A_CMPB_LO] = cmpBVal[BYTE_W-1:0];
    rdLane[A_CMPB_HI] = cmpBVal[CNT_W-1:BYTE_W];
    rdLane[A_CMODE_A] = cmodeA;
    rdLane[A_CMODE_B] = cmodeB;
    rdLane[A_CNT_LO]  = cntVal[BYTE_W-1:0];
    rdLane[A_CNT_HI]  = cntVal[CNT_W-1:BYTE_W];
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (busAddr == ADDR_W'(i))
        busRdata[BYTE_W-1:0] = rdLane[i];
      else if (busWide && (i % 2 == 1) && busAddr == ADDR_W'(i - 1))
        busRdata[BUS_W-1:BYTE_W] = rdLane[i];
    end
  end
endmodule

// File: rtl/upcmp_dpath.sv
module upcmp_dpath
  import upcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] cmpAVal,
  input  logic [CNT_W-1:0] cmpBVal,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] periodVal,
  output logic             periodPulse,
  output logic             matchA,
  output logic             matchB
);
  logic running, atTop;
  logic [CNT_W-1:0] nextCnt;

  assign running = ctrl.run && (periodVal != '0);
  assign atTop   = (cntVal == periodVal);
  assign nextCnt = atTop ? '0 : cntVal + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal      <= '0;
      periodVal   <= '0;
      periodPulse <= 1'b0;
      matchA      <= 1'b0;
      matchB      <= 1'b0;
    end else begin
      periodPulse <= 1'b0;
      matchA      <= 1'b0;
      matchB      <= 1'b0;
      if (ctrl.start) begin
        periodVal <= cmpAVal;
        cntVal    <= '0;
      end else if (ctrl.clear || !running) begin
        cntVal <= '0;
      end else if (tickEn) begin
        cntVal      <= nextCnt;
        periodPulse <= atTop;
        matchA      <= ctrl.enA && (nextCnt == periodVal);
        matchB      <= ctrl.enB && (nextCnt == cmpBVal) && (cmpBVal < periodVal);
      end
    end
  end
endmodule

// File: rtl/upcmp_timer.sv
module upcmp_timer
  import upcmp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              busErr,
  output logic              periodPulse,
  output logic              matchA,
  output logic              matchB
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] cntVal, periodVal, cmpAVal, cmpBVal;

  upcmp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busWide(busWide), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .cntVal(cntVal),
    .cmpAVal(cmpAVal), .cmpBVal(cmpBVal), .ctrl(ctrl)
  );

  upcmp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrl(ctrl), .cmpAVal(cmpAVal),
    .cmpBVal(cmpBVal), .cntVal(cntVal), .periodVal(periodVal),
    .periodPulse(periodPulse), .matchA(matchA), .matchB(matchB)
  );
endmodule

// File: rtl/upcmp_timer_chk.sv
module upcmp_timer_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              busWr,
  input logic              busWide,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        hiBits,
  input logic              busErr,
  input logic              run,
  input logic              start,
  input logic              clear,
  input logic [15:0]       cntVal,
  input logic [15:0]       periodVal,
  input logic [15:0]       cmpBVal,
  input logic              periodPulse,
  input logic              matchA,
  input logic              matchB
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && run && !start && !clear) |=> $stable(cntVal));

  a_r4_count_and_load_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busWide && busAddr == ADDR_W'(1) && hiBits == 2'b11) |=> busErr);

  a_r5_odd_wide_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busWide && busAddr[0]) |=> busErr);

  a_r7_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    periodPulse |=> !periodPulse);

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    periodPulse |-> (cntVal == 16'd0));

  a_r7_within_period: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cntVal <= periodVal));

  a_r9_b_below_period: assert property (@(posedge clk) disable iff (!rstN)
    matchB |-> ($past(cmpBVal) < $past(periodVal)));

  a_r10_zero_period_silent: assert property (@(posedge clk) disable iff (!rstN)
    (run && periodVal == 16'd0) |-> (!periodPulse && !matchA && !matchB));

  a_r11_stopped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (cntVal == 16'd0));
endmodule

bind upcmp_timer upcmp_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busWide(busWide),
  .busAddr(busAddr), .hiBits(busWdata[7:6]), .busErr(busErr), .run(ctrl.run),
  .start(ctrl.start), .clear(ctrl.clear), .cntVal(cntVal), .periodVal(periodVal),
  .cmpBVal(cmpBVal), .periodPulse(periodPulse), .matchA(matchA), .matchB(matchB)
);

// File: tb/upcmp_timer_bench.sv
`timescale 1ns/1ps
module upcmp_timer_bench;
  localparam int AW = 4;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, busWr = 1'b0, busWide = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic busErr, periodPulse, matchA, matchB;

  upcmp_timer #(.ADDR_W(AW)) u_upcmp_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busWide(busWide),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .periodPulse(periodPulse), .matchA(matchA), .matchB(matchB)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit monOn = 1'b0;

  typedef struct { int kind; int at; string tag; } evt_t;
  evt_t expQ[$];

  function automatic string kindTag(int k);
    return (k == 0) ? "R7" : (k == 1) ? "R8" : "R9";
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every pulse seen
  always @(negedge clk) begin
    logic [2:0] seen;
    seen = {matchB, matchA, periodPulse};
    if (rstN && monOn) begin
      for (int k = 0; k < 3; k++) begin
        if (seen[k]) begin
          nChecks++;
          if (expQ.size() == 0) begin
            nFails++;
            $display("FAIL %s unexpected pulse kind=%0d cycle=%0d expected none", kindTag(k), k, cyc);
          end else begin
            evt_t e;
            e = expQ.pop_front();
            if (e.kind != k || e.at != cyc) begin
              nFails++;
              $display("FAIL %s pulse actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                       e.tag, k, cyc, e.kind, e.at);
            end
          end
        end
      end
    end
  end

  task automatic busWrite(input logic [AW-1:0] a, input logic [15:0] d, input logic wide);
    busAddr = a; busWdata = d; busWide = wide; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busWide = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic wide, output logic [15:0] d);
    busAddr = a; busWide = wide; busWr = 1'b0;
    #1;
    d = busRdata;
  endtask

  task automatic pushEvt(int kind, int at, string tag);
    evt_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    expQ.push_back(e);
  endtask

  // driver: programs a run and pushes the expected pulses
  task automatic runPeriod(int p, int b, bit enA, bit enB, int nPer, bit midWrite);
    int e, stopAt;
    logic [15:0] d;
    string tag;
    busWrite(4'd2, 16'(p), 1'b1);
    busWrite(4'd4, 16'(b), 1'b1);
    busWrite(4'd6, {15'd0, enA}, 1'b0);
    busWrite(4'd7, {15'd0, enB}, 1'b0);
    e = cyc + 1;
    busWrite(4'd1, 16'h0080, 1'b0);
    for (int j = 0; j < nPer; j++) begin
      int base;
      base = e + j * (p + 1);
      tag = midWrite ? "R12" : "R9";
      if (enB && b > 0 && b < p) pushEvt(2, base + b, tag);
      tag = midWrite ? "R12" : "R8";
      if (enA) pushEvt(1, base + p, tag);
      tag = midWrite ? "R12" : "R7";
      pushEvt(0, base + p + 1, tag);
      tag = midWrite ? "R12" : "R9";
      if (enB && b == 0) pushEvt(2, base + p + 1, tag);
    end
    if (midWrite) begin
      busWrite(4'd2, 16'd1, 1'b1);
      busRead(4'd2, 1'b1, d);
      check("R12 compare A readback", int'(d), 1);
    end
    stopAt = e + nPer * (p + 1);
    while (cyc != stopAt) @(negedge clk);
    busWrite(4'd1, 16'h0000, 1'b0);
    busRead(4'd8, 1'b1, d);
    check("R11 counter after stop", int'(d), 0);
    repeat (p + 3) @(negedge clk);
    check("R7 scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    // R1 reset state
    check("R1 periodPulse", int'(periodPulse), 0);
    check("R1 matchA", int'(matchA), 0);
    check("R1 matchB", int'(matchB), 0);
    check("R1 busErr", int'(busErr), 0);
    for (int a = 0; a < 10; a += 2) begin
      busRead(AW'(a), 1'b1, d);
      check("R1 register pair", int'(d), 0);
    end

    // R3 reserved bits, wide mode write at address 0
    busWrite(4'd0, 16'h7FFF, 1'b1);
    check("R3 legal write no error", int'(busErr), 0);
    busRead(4'd0, 1'b1, d);
    check("R3 mode readback", int'(d), 16'h78D3);

    // R4 count plus load rejected
    busWrite(4'd1, 16'h00C0, 1'b0);
    check("R4 error strobe", int'(busErr), 1);
    @(negedge clk);
    check("R4 error one cycle", int'(busErr), 0);
    busRead(4'd1, 1'b0, d);
    check("R4 mode high unchanged", int'(d), 16'h0078);
    busWrite(4'd1, 16'h0000, 1'b0);

    // R6 address map and lanes
    busWrite(4'd2, 16'hA55A, 1'b1);
    busWrite(4'd3, 16'h0012, 1'b0);
    busRead(4'd2, 1'b1, d);
    check("R6 compare A wide", int'(d), 16'h125A);
    busRead(4'd3, 1'b0, d);
    check("R6 narrow read high byte", int'(d), 16'h0012);
    busWrite(4'd6, 16'h003C, 1'b0);
    busWrite(4'd7, 16'h00A1, 1'b0);
    busRead(4'd6, 1'b1, d);
    check("R6 compare-mode pair", int'(d), 16'hA13C);

    // R5 illegal accesses
    busWrite(4'd1, 16'h1234, 1'b1);
    check("R5 wide odd address", int'(busErr), 1);
    busWrite(4'd6, 16'h5555, 1'b1);
    check("R5 wide compare-mode", int'(busErr), 1);
    busRead(4'd6, 1'b1, d);
    check("R5 compare-mode unchanged", int'(d), 16'hA13C);
    busWrite(4'd8, 16'h0003, 1'b0);
    check("R5 counter write", int'(busErr), 1);
    busWrite(4'd12, 16'h0003, 1'b0);
    check("R5 unmapped address", int'(busErr), 1);
    busRead(4'd0, 1'b1, d);
    check("R5 mode unchanged", int'(d), 16'h00D3);

    // R2 tick gating
    busWrite(4'd2, 16'd100, 1'b1);
    busWrite(4'd6, 16'd0, 1'b0);
    busWrite(4'd7, 16'd0, 1'b0);
    busWrite(4'd1, 16'h0080, 1'b0);
    repeat (5) @(negedge clk);
    busRead(4'd8, 1'b1, d);
    check("R2 no tick holds zero", int'(d), 0);
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    tickEn = 1'b0;
    busRead(4'd8, 1'b1, d);
    check("R2 three ticks", int'(d), 3);
    repeat (4) @(negedge clk);
    busRead(4'd8, 1'b0, d);
    check("R2 held while tick low", int'(d), 3);
    busWrite(4'd1, 16'h0000, 1'b0);
    busRead(4'd8, 1'b1, d);
    check("R11 stop clears counter", int'(d), 0);

    tickEn = 1'b1;

    // R10 zero period stays idle
    busWrite(4'd2, 16'd0, 1'b1);
    busWrite(4'd1, 16'h0080, 1'b0);
    repeat (20) @(negedge clk);
    busRead(4'd8, 1'b1, d);
    check("R10 idle counter", int'(d), 0);
    busWrite(4'd1, 16'h0000, 1'b0);

    // R7 R8 R9 scoreboard runs
    runPeriod(5, 2, 1'b1, 1'b1, 3, 1'b0);
    runPeriod(4, 7, 1'b1, 1'b1, 2, 1'b0);  // R9 compare B above period
    runPeriod(3, 0, 1'b0, 1'b1, 2, 1'b0);  // R8 gated off, R9 at wrap
    runPeriod(1, 3, 1'b1, 1'b1, 3, 1'b0);
    runPeriod(5, 1, 1'b1, 1'b0, 2, 1'b1);  // R12 period kept

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule